// File: doc/BRIEF.md
# Aligned Block Loader for a Two-Dimensional Module Array

This block copies one aligned rectangle of pixels, ROWS tall and COLS wide, out of a frame held in a byte-wide-per-pixel linear memory into an array of ROWS×COLS small pixel memories. The frame is stored one pixel row after another. The linear memory returns BUS_BYTES pixels per read, so a whole rectangle costs ROWS·COLS/BUS_BYTES reads. After a start pulse with an aligned corner (row i, column j), the loader issues these reads on consecutive cycles. It steps across the column groups of one frame row before it moves to the next frame row.

Each returned word comes back a fixed RD_LAT cycles after its request. A short tag pipeline pairs the word with the step that asked for it. The word's bytes go to one row of the module array and to BUS_BYTES neighbouring columns of that row. A module is picked by the product of a one-hot row enable and a column enable. Every module in the array sees the same local address while the fill runs: the rectangle's index in the frame's grid of rectangles. A one-cycle done pulse closes the fill.

Top module: `block_fill_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, rdEn, every rowWe bit and every colWe bit are 0.
- R2: A start in an idle cycle with an aligned corner raises busy in the next cycle. From that cycle the block raises rdEn for exactly ROWS·COLS/BUS_BYTES consecutive cycles. rdEn and all write enables stay 0 whenever busy is 0.
- R3: Read step s (counted from 0) uses row offset k = s div (COLS/BUS_BYTES) and column group g = s mod (COLS/BUS_BYTES). Its address is (i+k)·FRAME_W + j + g·BUS_BYTES, so the column group is the fast index.
- R4: The word on rdData exactly RD_LAT cycles after the request of step (k,g) is written to module row k, columns g·BUS_BYTES+b for b in 0..BUS_BYTES−1. Byte b of rdData is bits [8b+7:8b], and column c reads its pixel from colData bits [8c+7:8c].
- R5: In a write cycle exactly one rowWe bit is 1 and exactly BUS_BYTES adjacent colWe bits are 1. A module (r,c) writes only when rowWe[r] and colWe[c] are both 1.
- R6: During a fill, modAddr equals (i/ROWS)·(FRAME_W/COLS) + j/COLS for every module and stays unchanged while busy is 1.
- R7: done is a one-cycle pulse in the cycle after the last write, and busy is 0 in that same cycle. For the defaults, done is seen in cycle ROWS·COLS/BUS_BYTES + RD_LAT + 1 after the start cycle.
- R8: A start raised while busy is 1 has no effect. No extra reads are issued, and the fill in progress keeps its addresses and data.
- R9: A start whose corner row is not a multiple of ROWS, or whose corner column is not a multiple of COLS, is ignored. busy stays 0 and no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to load the rectangle at the given corner |
| cornerRow | input | $clog2(FRAME_H) | Corner pixel row i |
| cornerCol | input | $clog2(FRAME_W) | Corner pixel column j |
| busy | output | 1 | A fill is in progress |
| done | output | 1 | One-cycle pulse after the last module write |
| rdEn | output | 1 | Linear memory read request |
| rdAddr | output | $clog2(FRAME_H·FRAME_W) | Linear pixel address of the request |
| rdData | input | 8·BUS_BYTES | Returned word, valid RD_LAT cycles after its request |
| rowWe | output | ROWS | Module row write enables |
| colWe | output | COLS | Module column write enables |
| modAddr | output | $clog2((FRAME_H/ROWS)·(FRAME_W/COLS)) | Local address shared by all modules |
| colData | output | 8·COLS | Pixel for each module column |

## Verification
With the default read latency of two cycles and four reads per rectangle, new reads are still being issued when the first words come back. For some cycles, one read request and the module write of an earlier word happen in the same cycle. The bench makes this overlap happen on every fill. It checks each read address in issue order and each write against the step order at the moment it happens, then compares every module pixel against the frame model. A start raised mid-fill adds a third event to one of these overlapping cycles, and that run must leave the read count and the written pixels unchanged.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } fillState_t;

  typedef struct packed {
    logic load;       // accept corner, clear step counters
    logic issue;      // a linear read goes out this cycle
    logic lastIssue;  // this read is the final step of the rectangle
  } fillCtl_t;
endpackage

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import bfs_pkg::*;
#(
  parameter int ROWS   = 2,
  parameter int GROUPS = 2,
  parameter int RIW    = 1,
  parameter int GIW    = 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startReq,
  input  logic           cornerOk,
  input  logic           lastWrite,
  output fillCtl_t       ctl,
  output logic [RIW-1:0] rowIdx,
  output logic [GIW-1:0] grpIdx,
  output logic           busy,
  output logic           done
);
  fillState_t state, stateNext;
  logic lastStep;

  assign lastStep = (rowIdx == RIW'(ROWS - 1)) && (grpIdx == GIW'(GROUPS - 1));

  always_comb begin
    ctl.load      = (state == ST_IDLE) && startReq && cornerOk;
    ctl.issue     = (state == ST_ISSUE);
    ctl.lastIssue = (state == ST_ISSUE) && lastStep;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (ctl.load) stateNext = ST_ISSUE;
      ST_ISSUE: if (ctl.lastIssue) stateNext = ST_DRAIN;
      ST_DRAIN: if (lastWrite) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rowIdx <= '0;
      grpIdx <= '0;
      done   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_DRAIN) && lastWrite;
      if (ctl.load) begin
        rowIdx <= '0;
        grpIdx <= '0;
      end else if (ctl.issue) begin
        if (grpIdx == GIW'(GROUPS - 1)) begin
          grpIdx <= '0;
          rowIdx <= rowIdx + 1'b1;
        end else begin
          grpIdx <= grpIdx + 1'b1;
        end
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/bfs_dpath.sv
module bfs_dpath
  import bfs_pkg::*;
#(
  parameter int ROWS      = 2,
  parameter int COLS      = 4,
  parameter int BUS_BYTES = 2,
  parameter int FRAME_W   = 16,
  parameter int FRAME_H   = 8,
  parameter int RD_LAT    = 2,
  parameter int PW        = 8,
  parameter int RAW       = 3,
  parameter int CAW       = 4,
  parameter int AW        = 7,
  parameter int LW        = 4,
  parameter int RIW       = 1,
  parameter int GIW       = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [RAW-1:0]        cornerRow,
  input  logic [CAW-1:0]        cornerCol,
  input  fillCtl_t              ctl,
  input  logic [RIW-1:0]        rowIdx,
  input  logic [GIW-1:0]        grpIdx,
  input  logic [BUS_BYTES*PW-1:0] rdData,
  output logic                  cornerOk,
  output logic                  rdEn,
  output logic [AW-1:0]         rdAddr,
  output logic [ROWS-1:0]       rowWe,
  output logic [COLS-1:0]       colWe,
  output logic [LW-1:0]         modAddr,
  output logic [COLS*PW-1:0]    colData,
  output logic                  lastWrite
);
  logic [RAW-1:0] baseRow;
  logic [CAW-1:0] baseCol;

  assign cornerOk = (int'(cornerRow) % ROWS == 0) && (int'(cornerCol) % COLS == 0)
                 && (int'(cornerRow) <= FRAME_H - ROWS) && (int'(cornerCol) <= FRAME_W - COLS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseRow <= '0;
      baseCol <= '0;
      modAddr <= '0;
    end else if (ctl.load) begin
      baseRow <= cornerRow;
      baseCol <= cornerCol;
      modAddr <= LW'(int'(cornerRow) / ROWS * (FRAME_W / COLS) + int'(cornerCol) / COLS);
    end
  end

  assign rdEn   = ctl.issue;
  assign rdAddr = AW'((int'(baseRow) + int'(rowIdx)) * FRAME_W
                      + int'(baseCol) + int'(grpIdx) * BUS_BYTES);

  // Tag pipeline: one stage per cycle of read latency
  logic           tagValid [RD_LAT];
  logic           tagLast  [RD_LAT];
  logic [RIW-1:0] tagRow   [RD_LAT];
  logic [GIW-1:0] tagGrp   [RD_LAT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagValid[0] <= 1'b0;
      tagLast[0]  <= 1'b0;
    end else begin
      tagValid[0] <= ctl.issue;
      tagLast[0]  <= ctl.lastIssue;
    end
    tagRow[0] <= rowIdx;
    tagGrp[0] <= grpIdx;
  end

  for (genvar s = 1; s < RD_LAT; s++) begin : g_tagStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagValid[s] <= 1'b0;
        tagLast[s]  <= 1'b0;
      end else begin
        tagValid[s] <= tagValid[s-1];
        tagLast[s]  <= tagLast[s-1];
      end
      tagRow[s] <= tagRow[s-1];
      tagGrp[s] <= tagGrp[s-1];
    end
  end

  logic           outValid;
  logic [RIW-1:0] outRow;
  logic [GIW-1:0] outGrp;

  assign outValid  = tagValid[RD_LAT-1];
  assign outRow    = tagRow[RD_LAT-1];
  assign outGrp    = tagGrp[RD_LAT-1];
  assign lastWrite = outValid && tagLast[RD_LAT-1];

  for (genvar r = 0; r < ROWS; r++) begin : g_rowEn
    assign rowWe[r] = outValid && (outRow == RIW'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colEn
    assign colWe[c] = outValid && (outGrp == GIW'(c / BUS_BYTES));
    assign colData[c*PW +: PW] = rdData[(c % BUS_BYTES)*PW +: PW];
  end
endmodule

// File: rtl/block_fill_seq.sv
module block_fill_seq
  import bfs_pkg::*;
#(
  parameter int ROWS      = 2,
  parameter int COLS      = 4,
  parameter int BUS_BYTES = 2,
  parameter int FRAME_W   = 16,
  parameter int FRAME_H   = 8,
  parameter int RD_LAT    = 2,
  localparam int PW       = 8,
  localparam int RAW      = $clog2(FRAME_H),
  localparam int CAW      = $clog2(FRAME_W),
  localparam int AW       = $clog2(FRAME_H * FRAME_W),
  localparam int LW       = $clog2((FRAME_H / ROWS) * (FRAME_W / COLS)),
  localparam int GROUPS   = COLS / BUS_BYTES,
  localparam int RIW      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int GIW      = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startReq,
  input  logic [RAW-1:0]          cornerRow,
  input  logic [CAW-1:0]          cornerCol,
  output logic                    busy,
  output logic                    done,
  output logic                    rdEn,
  output logic [AW-1:0]           rdAddr,
  input  logic [BUS_BYTES*PW-1:0] rdData,
  output logic [ROWS-1:0]         rowWe,
  output logic [COLS-1:0]         colWe,
  output logic [LW-1:0]           modAddr,
  output logic [COLS*PW-1:0]      colData
);
  fillCtl_t       ctl;
  logic [RIW-1:0] rowIdx;
  logic [GIW-1:0] grpIdx;
  logic           cornerOk;
  logic           lastWrite;

  bfs_ctrl #(.ROWS(ROWS), .GROUPS(GROUPS), .RIW(RIW), .GIW(GIW)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cornerOk(cornerOk),
    .lastWrite(lastWrite), .ctl(ctl), .rowIdx(rowIdx), .grpIdx(grpIdx),
    .busy(busy), .done(done)
  );

  bfs_dpath #(
    .ROWS(ROWS), .COLS(COLS), .BUS_BYTES(BUS_BYTES), .FRAME_W(FRAME_W),
    .FRAME_H(FRAME_H), .RD_LAT(RD_LAT), .PW(PW), .RAW(RAW), .CAW(CAW),
    .AW(AW), .LW(LW), .RIW(RIW), .GIW(GIW)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .cornerRow(cornerRow), .cornerCol(cornerCol),
    .ctl(ctl), .rowIdx(rowIdx), .grpIdx(grpIdx), .rdData(rdData),
    .cornerOk(cornerOk), .rdEn(rdEn), .rdAddr(rdAddr), .rowWe(rowWe),
    .colWe(colWe), .modAddr(modAddr), .colData(colData), .lastWrite(lastWrite)
  );
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int ROWS      = 2,
  parameter int COLS      = 4,
  parameter int BUS_BYTES = 2,
  parameter int LW        = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            done,
  input logic            rdEn,
  input logic [ROWS-1:0] rowWe,
  input logic [COLS-1:0] colWe,
  input logic [LW-1:0]   modAddr
);
  assert_row_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|colWe) |-> ($countones(rowWe) == 1));

  assert_col_group_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|rowWe) |-> ($countones(colWe) == BUS_BYTES));

  assert_write_in_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|rowWe) |-> busy);

  assert_read_in_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> busy);

  assert_local_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(modAddr));

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(|rowWe)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind block_fill_seq bfs_checker #(
  .ROWS(ROWS), .COLS(COLS), .BUS_BYTES(BUS_BYTES), .LW(LW)
) i_bfsChecker (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .rdEn(rdEn),
  .rowWe(rowWe), .colWe(colWe), .modAddr(modAddr)
);

// File: tb/test_block_fill_seq.sv
module test_block_fill_seq;
  localparam int ROWS = 2, COLS = 4, BW = 2, FW = 16, FH = 8, LAT = 2;
  localparam int GROUPS = COLS / BW;
  localparam int STEPS = ROWS * GROUPS;
  localparam int AW = 7, LW = 4;
  localparam int NVEC = 6;
  // corner row, corner column, expected local address
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 0}, '{2, 4, 5}, '{6, 12, 15}, '{4, 8, 10}, '{0, 12, 3}, '{6, 0, 12}
  };

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0;
  logic [2:0] cornerRow = '0;
  logic [3:0] cornerCol = '0;
  logic busy, done, rdEn;
  logic [AW-1:0] rdAddr;
  logic [BW*8-1:0] rdData;
  logic [ROWS-1:0] rowWe;
  logic [COLS-1:0] colWe;
  logic [LW-1:0] modAddr;
  logic [COLS*8-1:0] colData;

  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  block_fill_seq #(.ROWS(ROWS), .COLS(COLS), .BUS_BYTES(BW), .FRAME_W(FW),
                   .FRAME_H(FH), .RD_LAT(LAT)) i_block_fill_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cornerRow(cornerRow),
    .cornerCol(cornerCol), .busy(busy), .done(done), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .rowWe(rowWe), .colWe(colWe), .modAddr(modAddr), .colData(colData));

  function automatic logic [7:0] pix(int a);
    return 8'(a * 7 + 3);
  endfunction

  // Linear frame memory model with fixed latency
  logic [AW-1:0] pipe [LAT];
  always @(posedge clk) begin
    pipe[0] <= rdAddr;
    for (int s = 1; s < LAT; s++) pipe[s] <= pipe[s-1];
  end
  always_comb
    for (int b = 0; b < BW; b++) rdData[b*8 +: 8] = pix(int'(pipe[LAT-1]) + b);

  // Module array model and port monitor
  logic [7:0] bank [ROWS][COLS][16];
  int curI = 0, curJ = 0, curLA = 0;
  int readCnt = 0, writeCnt = 0, badRd = 0, badWr = 0, badLocal = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rdEn) begin
        if (int'(rdAddr) != (curI + readCnt / GROUPS) * FW + curJ + (readCnt % GROUPS) * BW)
          badRd++;
        readCnt++;
      end
      if ((|rowWe) || (|colWe)) begin
        if (rowWe != ROWS'(1 << (writeCnt / GROUPS)) ||
            colWe != COLS'(((1 << BW) - 1) << ((writeCnt % GROUPS) * BW)))
          badWr++;
        if (int'(modAddr) != curLA) badLocal++;
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++)
            if (rowWe[r] && colWe[c]) bank[r][c][modAddr] = colData[c*8 +: 8];
        writeCnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearState(int i, int j, int la);
    curI = i; curJ = j; curLA = la;
    readCnt = 0; writeCnt = 0; badRd = 0; badWr = 0; badLocal = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int a = 0; a < 16; a++) bank[r][c][a] = 8'h00;
  endtask

  // Runs one fill; optional interfering start at cycle 2 (R8)
  task automatic runFill(int i, int j, int la, bit interfere);
    int lat = 0;
    clearState(i, j, la);
    cornerRow = 3'(i); cornerCol = 4'(j); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0; lat = 1;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!done && lat < 60) begin
      if (interfere && lat == 2) begin
        cornerRow = 3'(4); cornerCol = 4'(8); startReq = 1'b1;
      end else startReq = 1'b0;
      @(negedge clk); lat++;
    end
    startReq = 1'b0;
    check(lat == STEPS + LAT + 1, "R7 done latency", lat, STEPS + LAT + 1);
    check(busy == 1'b0, "R7 busy low with done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    check(readCnt == STEPS, interfere ? "R8 read count" : "R2 read count", readCnt, STEPS);
    check(badRd == 0, "R3 read address order", badRd, 0);
    check(writeCnt == STEPS && badWr == 0, "R5 write enables", badWr, 0);
    check(badLocal == 0, "R6 local address", badLocal, 0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        check(bank[r][c][la] == pix((i + r) * FW + j + c),
              interfere ? "R8 pixel kept" : "R4 pixel placement",
              int'(bank[r][c][la]), int'(pix((i + r) * FW + j + c)));
  endtask

  task automatic tryUnaligned(int i, int j);
    clearState(0, 0, 0);
    cornerRow = 3'(i); cornerCol = 4'(j); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    repeat (8) @(negedge clk);
    check(busy == 1'b0 && readCnt == 0, "R9 unaligned ignored", readCnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rdEn && rowWe == 0 && colWe == 0, "R1 in reset",
          int'({busy, done, rdEn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rdEn && rowWe == 0 && colWe == 0, "R1 after reset",
          int'({busy, done, rdEn}), 0);

    for (int v = 0; v < NVEC; v++) runFill(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);

    runFill(2, 4, 5, 1'b1);
    tryUnaligned(1, 4);
    tryUnaligned(2, 6);
    runFill(6, 12, 15, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule